// File: doc/BRIEF.md
# Lockable Watchdog Timer Controller

This block is a watchdog timer. A free-running counter runs on its own counter clock. When the counter bit chosen by a prescale field rises, the block raises a one-cycle reset request in the bus clock domain. Software reaches a single control register through a simple write port. Every write must carry a key byte. A clear command restarts the counter, and a busy flag stays set until the clear has reached the counter domain and come back.

Several control fields change state only under conditions:
- The enable bit reads back as cleared only once the counter domain has seen the disable. If the counter clock gate is off at that point, the disable never arrives.
- A sticky lock bit freezes the register until the next reset of any kind.
- The mode bit can change only while the timer reads as disabled.

On a reset the block looks at the reset cause and at a calibration-done flag. From these it decides whether to keep the watchdog setup or reload the defaults. When the auto-enable input is high, the defaults start the timer. A calibration request output stays high until an external engine reports completion with a done pulse.

Top module: `wdt_lock_ctrl`

## Requirements
- R1: A write to the control register takes effect only when `wr_data[31:24]` equals 0xA5. Any other key leaves the register unchanged.
- R2: `rd_data` layout:
  - bit 0: enable
  - bit 1: counter-clock enable
  - bit 2: mode (0 basic, 1 windowed)
  - bit 3: disable-after-reset
  - bit 4: lock
  - bit 6: clear busy
  - bit 7: calibration done
  - bits 12:8: prescale select
  - all other bits read 0
  
  Bits 7 and 6 cannot be written.
- R3: After a keyed write clears enable, bit 0 keeps reading 1 until the disable has passed through the counter domain and back. It then reads 0, provided the counter-clock enable is 1.
- R4: If the counter-clock enable is 0 when enable is cleared, bit 0 keeps reading 1.
- R5: A keyed write accepted with the lock bit at 1 sets the lock. From then on, every write leaves all writable fields unchanged until a reset.
- R6: A keyed write changes the mode bit only if bit 0 read 0 in the cycle of the write. Otherwise mode is unchanged.
- R7: A reset that reloads defaults sets the register as follows:
  - enable and counter-clock enable equal to `auto_en`
  - mode 0, lock 0, disable-after-reset 0, calibration done 0
  - prescale select 7, which with the default parameters gives a timeout above 100 ms at 115 kHz
- R8: A reset with `rst_cause_wdt`=1 while calibration done is 1 keeps every field except the lock, which clears.
- R9: In the reset of R8, if disable-after-reset is 1, enable is cleared.
- R10: Calibration done is set only by a `cal_done` pulse outside reset. It is cleared by any reset that reloads defaults: either a reset that is not a watchdog reset, or a watchdog reset while it was 0. `cal_req` is high exactly while calibration done is 0.
- R11: A timeout occurs when counter bit (7 + prescale select) rises, and `wdt_rst_req` then pulses for one clock.
  - Basic mode restarts the counter, so timeouts repeat every 2^(7+psel) counter clocks.
  - Windowed mode does not restart it, so the period is 2^(8+psel) counter clocks.
- R12: A `clr_req` pulse zeroes the counter via a toggle handshake, and bit 6 reads 1 from the next cycle until the handshake returns. A clear in the same counter cycle as a timeout wins, and no request is raised.
- R13: A `cal_done` pulse in the same cycle as a keyed write sets calibration done, and the write's fields are also applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| cnt_clk | input | 1 | Counter clock |
| por_n | input | 1 | Power-on/debug reset, active low, clears configuration |
| rst_n | input | 1 | System reset (any cause), active low |
| auto_en | input | 1 | Start enabled after a default-loading reset |
| rst_cause_wdt | input | 1 | Current reset was caused by the watchdog |
| cal_done | input | 1 | Calibration finished pulse |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Write data with key in bits 31:24 |
| clr_req | input | 1 | Counter clear command pulse |
| rd_data | output | 32 | Control register read value |
| cal_req | output | 1 | Calibration requested |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
A calibration-done pulse and a keyed register write can land in the same bus cycle. The bench drives both on one edge and expects calibration done set together with every written field. A clear command and a timeout can land in the same counter cycle. The bench forces this by issuing clears at a period shorter than the shortest timeout and requires that no reset request appears over many would-be timeout periods.

// File: rtl/wdt_lock_pkg.sv
`timescale 1ns/1ps
package wdt_lock_pkg;
  localparam int CNT_W    = 32;
  localparam int TAP_BASE = 7;
  localparam int PSEL_W   = 5;
  localparam int KEY_W    = 8;
  localparam logic [KEY_W-1:0] WR_KEY = 8'hA5;
  localparam int MAX_SEL  = CNT_W - 1 - TAP_BASE;

  // bit positions shared by read and write data
  localparam int B_EN    = 0;
  localparam int B_CEN   = 1;
  localparam int B_MODE  = 2;
  localparam int B_DAR   = 3;
  localparam int B_LOCK  = 4;
  localparam int B_BUSY  = 6;
  localparam int B_FCD   = 7;
  localparam int PSEL_LO = 8;
  localparam int KEY_LO  = 32 - KEY_W;

  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic              fcd;
    logic              lock;
    logic              dar;
    logic              mode;
    logic              cen;
    logic              en;
  } wdt_cfg_t;

  // smallest prescale whose first timeout exceeds min_ms at hz
  function automatic logic [PSEL_W-1:0] nom_psel(input longint hz, input longint min_ms);
    logic [PSEL_W-1:0] sel;
    logic              found;
    sel   = PSEL_W'(MAX_SEL);
    found = 1'b0;
    for (int k = TAP_BASE; k < CNT_W; k++) begin
      if (!found && ((longint'(1) << k) * 1000 > hz * min_ms)) begin
        sel   = PSEL_W'(k - TAP_BASE);
        found = 1'b1;
      end
    end
    return sel;
  endfunction
endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
module wdt_ctrl_reg
  import wdt_lock_pkg::*;
#(
  parameter logic [PSEL_W-1:0] RST_PSEL = 5'd7
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        auto_en,
  input  logic        rst_cause_wdt,
  input  logic        cal_done,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        en_ack,
  output wdt_cfg_t    cfg,
  output logic        en_rd
);
  wdt_cfg_t cfg_q, cfg_d, dflt;
  logic     key_ok, wr_ok;

  assign en_rd  = cfg_q.en | en_ack;
  assign key_ok = (wr_data[KEY_LO +: KEY_W] == WR_KEY);
  assign wr_ok  = wr_en && key_ok && !cfg_q.lock;

  always_comb begin
    dflt      = '0;
    dflt.psel = RST_PSEL;
    dflt.en   = auto_en;
    dflt.cen  = auto_en;
  end

  always_comb begin
    cfg_d = cfg_q;
    if (!rst_n) begin
      if (rst_cause_wdt && cfg_q.fcd) begin
        cfg_d.lock = 1'b0;
        if (cfg_q.dar) cfg_d.en = 1'b0;
      end else begin
        cfg_d = dflt;
      end
    end else begin
      if (wr_ok) begin
        cfg_d.en   = wr_data[B_EN];
        cfg_d.cen  = wr_data[B_CEN];
        cfg_d.dar  = wr_data[B_DAR];
        cfg_d.lock = wr_data[B_LOCK];
        cfg_d.psel = wr_data[PSEL_LO +: PSEL_W];
        if (!en_rd) cfg_d.mode = wr_data[B_MODE];
      end
      if (cal_done) cfg_d.fcd = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg_q      <= '0;
      cfg_q.psel <= RST_PSEL;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // R5: locked register ignores writes
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lock && wr_en) |=>
      $stable({cfg_q.en, cfg_q.cen, cfg_q.mode, cfg_q.dar, cfg_q.lock, cfg_q.psel}));
  // R6: mode frozen while enable reads 1
  p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && en_rd) |=> $stable(cfg_q.mode));
  // R10: calibration flag only set by done pulse
  p_fcd_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q.fcd) |-> $past(cal_done));
  // R3: enable read falls only after the stored enable is low
  p_en_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_rd) |-> $past(!cfg_q.en));
endmodule

// File: rtl/wdt_cnt_core.sv
`timescale 1ns/1ps
module wdt_cnt_core
  import wdt_lock_pkg::*;
(
  input  logic              cnt_clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              cen_s,
  input  logic              clr_s,
  input  logic              mode,
  input  logic [PSEL_W-1:0] psel,
  output logic              en_act,
  output logic              clr_ack,
  output logic              to_tgl
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic              en_act_q, en_act_d;
  logic              clr_seen_q;
  logic              to_q, to_d;
  logic              run, hit, clr_evt;
  logic [PSEL_W-1:0] sel;
  logic [5:0]        tap_idx;

  assign clr_evt = clr_s ^ clr_seen_q;
  assign run     = cen_s & en_act_q;
  assign sel     = (int'(psel) > MAX_SEL) ? PSEL_W'(MAX_SEL) : psel;
  assign tap_idx = 6'(TAP_BASE) + 6'(sel);
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = run & cnt_inc[tap_idx] & ~cnt_q[tap_idx];

  always_comb begin
    en_act_d = cen_s ? en_s : en_act_q;
    cnt_d    = cnt_q;
    to_d     = to_q;
    if (clr_evt) begin
      cnt_d = '0;
    end else if (run) begin
      if (hit) begin
        to_d  = ~to_q;
        cnt_d = mode ? cnt_inc : '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge cnt_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      en_act_q   <= 1'b0;
      clr_seen_q <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      en_act_q   <= en_act_d;
      clr_seen_q <= clr_s;
      to_q       <= to_d;
    end
  end

  assign en_act  = en_act_q;
  assign clr_ack = clr_seen_q;
  assign to_tgl  = to_q;

  // R12: a clear event leaves the counter at zero
  p_clear_zero_r12: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    clr_evt |=> (cnt_q == '0));
  // R4: gated counter clock freezes the enable state
  p_gate_hold_r4: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    !cen_s |=> $stable(en_act_q));
  // R12: a clear suppresses the timeout toggle
  p_clear_wins_r12: assert property (@(posedge cnt_clk) disable iff (!rst_n)
    clr_evt |=> $stable(to_q));
endmodule

// File: rtl/wdt_lock_ctrl.sv
`timescale 1ns/1ps
module wdt_lock_ctrl
  import wdt_lock_pkg::*;
#(
  parameter longint CNT_HZ     = 115000,
  parameter longint MIN_TO_MS  = 100
) (
  input  logic        clk,
  input  logic        cnt_clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        auto_en,
  input  logic        rst_cause_wdt,
  input  logic        cal_done,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        clr_req,
  output logic [31:0] rd_data,
  output logic        cal_req,
  output logic        wdt_rst_req
);
  localparam logic [PSEL_W-1:0] RST_PSEL = nom_psel(CNT_HZ, MIN_TO_MS);

  wdt_cfg_t   cfg;
  logic       en_rd, en_ack_s, clr_ack_s, to_s;
  logic       en_s, cen_s, clr_s;
  logic       en_act, clr_ack, to_tgl;
  logic       clr_tgl_q, clr_tgl_d, to_seen_q, req_q, req_d, busy;
  logic [2:0] to_cnt_dom, from_cnt_dom;

  wdt_ctrl_reg #(.RST_PSEL(RST_PSEL)) u_reg (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .auto_en(auto_en),
    .rst_cause_wdt(rst_cause_wdt), .cal_done(cal_done), .wr_en(wr_en),
    .wr_data(wr_data), .en_ack(en_ack_s), .cfg(cfg), .en_rd(en_rd)
  );

  wdt_sync #(.W(3)) u_sync_in (
    .clk(cnt_clk), .rst_n(rst_n),
    .d({cfg.en, cfg.cen, clr_tgl_q}), .q(to_cnt_dom)
  );
  assign {en_s, cen_s, clr_s} = to_cnt_dom;

  wdt_cnt_core u_core (
    .cnt_clk(cnt_clk), .rst_n(rst_n), .en_s(en_s), .cen_s(cen_s),
    .clr_s(clr_s), .mode(cfg.mode), .psel(cfg.psel),
    .en_act(en_act), .clr_ack(clr_ack), .to_tgl(to_tgl)
  );

  wdt_sync #(.W(3)) u_sync_out (
    .clk(clk), .rst_n(rst_n),
    .d({en_act, clr_ack, to_tgl}), .q(from_cnt_dom)
  );
  assign {en_ack_s, clr_ack_s, to_s} = from_cnt_dom;

  assign busy = clr_tgl_q ^ clr_ack_s;

  always_comb begin
    clr_tgl_d = (clr_req && !busy) ? ~clr_tgl_q : clr_tgl_q;
    req_d     = to_s ^ to_seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_tgl_q <= 1'b0;
      to_seen_q <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      clr_tgl_q <= clr_tgl_d;
      to_seen_q <= to_s;
      req_q     <= req_d;
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[B_EN]              = en_rd;
    rd_data[B_CEN]             = cfg.cen;
    rd_data[B_MODE]            = cfg.mode;
    rd_data[B_DAR]             = cfg.dar;
    rd_data[B_LOCK]            = cfg.lock;
    rd_data[B_BUSY]            = busy;
    rd_data[B_FCD]             = cfg.fcd;
    rd_data[PSEL_LO +: PSEL_W] = cfg.psel;
  end

  assign cal_req     = ~cfg.fcd;
  assign wdt_rst_req = req_q;

  // R11: reset request is a single-cycle pulse
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req);
  // R12: busy only rises after a clear command
  p_busy_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(clr_req));
endmodule

// File: tb/wdt_lock_ctrl_bench.sv
`timescale 1ns/1ps
module wdt_lock_ctrl_bench;
  logic        clk = 1'b0, cnt_clk = 1'b0;
  logic        por_n, rst_n, auto_en, rst_cause_wdt, cal_done;
  logic        wr_en, clr_req;
  logic [31:0] wr_data, rd_data;
  logic        cal_req, wdt_rst_req;

  int          n_chk = 0, n_fail = 0, req_cnt = 0;
  longint      t_last = 0, t_prev = 0;
  logic        done = 1'b0;

  localparam int CNT_PER = 14;

  always #5 clk = ~clk;
  always #7 cnt_clk = ~cnt_clk;

  wdt_lock_ctrl u_wdt_lock_ctrl (
    .clk(clk), .cnt_clk(cnt_clk), .por_n(por_n), .rst_n(rst_n),
    .auto_en(auto_en), .rst_cause_wdt(rst_cause_wdt), .cal_done(cal_done),
    .wr_en(wr_en), .wr_data(wr_data), .clr_req(clr_req),
    .rd_data(rd_data), .cal_req(cal_req), .wdt_rst_req(wdt_rst_req)
  );

  always @(negedge clk) if (wdt_rst_req) begin
    t_prev = t_last;
    t_last = $time;
    req_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input longint act, input longint exp);
    n_chk++;
    if (act > exp + 12 || act < exp - 12) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] d, input logic with_cal);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; cal_done = with_cal;
    @(negedge clk);
    wr_en = 1'b0; cal_done = 1'b0;
  endtask

  task automatic do_reset(input logic por, input logic wdt, input logic auto);
    @(negedge clk);
    if (por) por_n = 1'b0;
    rst_n = 1'b0; rst_cause_wdt = wdt; auto_en = auto;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; rst_cause_wdt = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_reqs(input int n);
    int target;
    target = req_cnt + n;
    while (req_cnt < target) @(negedge clk);
  endtask

  function automatic logic [31:0] model_wr(input logic [31:0] cur, input logic [31:0] d,
                                           input logic en_now);
    logic [31:0] n;
    n = cur;
    if (d[31:24] == 8'hA5 && !cur[4]) begin
      n[0] = d[0]; n[1] = d[1]; n[3] = d[3]; n[4] = d[4];
      n[12:8] = d[12:8];
      if (!en_now) n[2] = d[2];
    end
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_v, d;
    void'($urandom(32'd17));
    por_n = 1'b0; rst_n = 1'b0; auto_en = 1'b0; rst_cause_wdt = 1'b0;
    cal_done = 1'b0; wr_en = 1'b0; wr_data = '0; clr_req = 1'b0;

    // A: power-on defaults
    do_reset(1'b1, 1'b0, 1'b0);
    chk("R7 reset value", rd_data, 32'h0000_0700);
    chk("R10 cal_req after reset", {31'd0, cal_req}, 32'd1);
    chk("R11 no request at reset", {31'd0, wdt_rst_req}, 32'd0);

    // B: write and calibration done in one cycle
    bus_wr(32'hA500_0502, 1'b1);
    chk("R13 write with cal_done", rd_data, 32'h0000_0582);
    chk("R10 cal_req dropped", {31'd0, cal_req}, 32'd0);

    // C: bad key
    bus_wr(32'h5A00_0001, 1'b0);
    chk("R1 wrong key ignored", rd_data, 32'h0000_0582);

    // D: random keyed/unkeyed writes with enable held low
    exp_v = 32'h0000_0582;
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      d[0] = 1'b0; d[4] = 1'b0;
      if ($urandom_range(0, 1) == 1) d[31:24] = 8'hA5;
      else if (d[31:24] == 8'hA5) d[31:24] = 8'h00;
      exp_v = model_wr(exp_v, d, 1'b0);
      bus_wr(d, 1'b0);
      chk("R1 R2 random write", rd_data, exp_v);
    end

    // E: enable basic mode psel 0
    bus_wr(32'hA500_0003, 1'b0);
    chk("R2 enabled read", rd_data, 32'h0000_0083);
    bus_wr(32'hA500_0007, 1'b0);
    chk("R6 mode blocked while enabled", rd_data, 32'h0000_0083);
    wait_reqs(3);
    chk_near("R11 basic period", t_last - t_prev, 128 * CNT_PER);

    // R12: repeated clears shorter than the timeout period
    begin
      int base;
      @(negedge clk);
      base = req_cnt;
      for (int i = 0; i < 30; i++) begin
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        if (i == 0) chk("R12 busy set", {31'd0, rd_data[6]}, 32'd1);
        repeat (20) @(negedge clk);
        if (i == 0) chk("R12 busy cleared", {31'd0, rd_data[6]}, 32'd0);
        repeat (59) @(negedge clk);
      end
      chk("R12 clears keep off timeout", req_cnt - base, 32'd0);
    end

    // F: disable handshake
    bus_wr(32'hA500_0002, 1'b0);
    chk("R3 enable still reads 1", rd_data, 32'h0000_0083);
    repeat (30) @(negedge clk);
    chk("R3 enable reads 0", rd_data, 32'h0000_0082);
    bus_wr(32'hA500_0006, 1'b0);
    chk("R6 mode accepted while disabled", rd_data, 32'h0000_0086);
    bus_wr(32'hA500_0007, 1'b0);
    wait_reqs(3);
    chk_near("R11 windowed period", t_last - t_prev, 256 * CNT_PER);

    // G: disable with counter clock gated
    bus_wr(32'hA500_0004, 1'b0);
    repeat (50) @(negedge clk);
    chk("R4 enable stuck at 1", rd_data, 32'h0000_0085);
    bus_wr(32'hA500_0006, 1'b0);
    repeat (30) @(negedge clk);
    chk("R3 enable clears once gate opens", rd_data, 32'h0000_0086);

    // H: lock
    bus_wr(32'hA500_021B, 1'b0);
    chk("R5 lock write applied", rd_data, 32'h0000_029B);
    bus_wr(32'hA500_0000, 1'b0);
    chk("R5 locked write ignored", rd_data, 32'h0000_029B);

    // I: watchdog reset with calibration done and disable-after-reset
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R8 R9 config kept, enable dropped", rd_data, 32'h0000_028A);

    // J: watchdog reset keeping enable
    bus_wr(32'hA500_0203, 1'b0);
    chk("R5 lock released by reset", rd_data, 32'h0000_0283);
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R8 config kept", rd_data, 32'h0000_0283);

    // K: ordinary reset with auto-enable
    do_reset(1'b0, 1'b0, 1'b1);
    chk("R7 auto-enable defaults", rd_data, 32'h0000_0703);
    chk("R10 cal_req after plain reset", {31'd0, cal_req}, 32'd1);

    // L: watchdog reset before calibration finished
    do_reset(1'b0, 1'b1, 1'b0);
    chk("R10 defaults on wdt reset without cal", rd_data, 32'h0000_0700);
    chk("R10 cal_req rerun", {31'd0, cal_req}, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule